// File: doc/BRIEF.md
# Sign-Gradient Step-Error Tracker

This block is the slow-rate optimiser of a digital background calibration loop for a two-stage converter. Each time an upstream estimator publishes a fresh harmonic-power figure, the tracker compares it with the figure it stored on the previous publication. It then moves a signed fixed-point step-error estimate one fixed increment in the direction that the sign of the power change dictates. Repeated over many slow periods, the estimate settles around the value where harmonic power is lowest. A downstream corrector uses that value.

The power strobe is expected once per slow period of four scan lines. Only the sign of the power difference is used, so no multiplier or divider is needed. The estimate is held in two's complement with `FRAC_W` fractional bits. The increment is 1/32 of a converter LSB, which is `2**(FRAC_W-5)` code units. The estimate clamps at its signed range limits.

Top module: `sign_grad_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `est_code` becomes 0 and `est_valid` becomes 0.
- R2: The first `pwr_valid` strobe after reset only stores the power value. It produces no `est_valid` pulse and leaves `est_code` at 0.
- R3: On a later strobe whose power is strictly greater than the stored power, `est_code` increases by one increment. The increment is 1/32 LSB, which is 1 code unit when `FRAC_W` = 5. The new value and a one-cycle `est_valid` pulse appear on the second rising edge after the strobe edge.
- R4: On a later strobe whose power is strictly less than the stored power, `est_code` decreases by one increment, with the same timing as R3.
- R5: On a later strobe whose power equals the stored power, `est_code` is unchanged, but `est_valid` still pulses with the timing of R3.
- R6: An increase that would exceed the largest signed value, 2^(CODE_W-1)-1, leaves `est_code` at that value. It never wraps.
- R7: A decrease that would fall below the smallest signed value, -2^(CODE_W-1), leaves `est_code` at that value.
- R8: `est_code` changes only in a cycle where `est_valid` is 1.
- R9: `pwr_value` is ignored while `pwr_valid` is low. The comparison always uses the power captured at the most recent strobe.
- R10: `est_valid` is high exactly one cycle for each strobe after the first. It is high two cycles after the strobe edge and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_valid | input | 1 | One-cycle strobe marking a new harmonic-power value |
| pwr_value | input | PWR_W | Unsigned harmonic-power value |
| est_code | output | CODE_W | Two's complement step-error estimate, FRAC_W fractional bits |
| est_valid | output | 1 | One-cycle pulse marking an evaluated update of est_code |

## Verification
The bench builds the tracker with an 8-bit estimate, 5 fractional bits and 12-bit power. With these values a single increment is one code unit, and both clamp limits (+127 and -128) can be reached with about a hundred and thirty consecutive steps in one direction. This lets the bench drive the estimate into each limit and hold it there against further pushes. The random power values are drawn from a narrow range, so equal consecutive values and the hold case of R5 occur often. A mid-run reset shows that the first-strobe rule of R2 applies again.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

    // Direction chosen from the sign of the power change
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    // Output of the slope sensor: an evaluated direction and its qualifier
    typedef struct packed {
        logic vld;
        dir_e dir;
    } slope_t;

    // Sign of a signed difference mapped to a direction
    function automatic dir_e dir_of(input logic neg, input logic zero);
        if (zero)     return DIR_HOLD;
        else if (neg) return DIR_DOWN;
        else          return DIR_UP;
    endfunction

endpackage

// File: rtl/sgt_slope_sense.sv
module sgt_slope_sense
    import sgt_pkg::*;
#(
    parameter int PWR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_valid,
    input  logic [PWR_W-1:0] pwr_value,
    output slope_t           slope
);
    localparam int DIFF_W = PWR_W + 1;

    logic [PWR_W-1:0]        prev_q;
    logic                    have_q;
    logic signed [DIFF_W-1:0] diff;

    // current minus previous, both zero-extended
    assign diff = $signed({1'b0, pwr_value}) - $signed({1'b0, prev_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            have_q    <= 1'b0;
            slope.vld <= 1'b0;
            slope.dir <= DIR_HOLD;
        end else begin
            slope.vld <= pwr_valid && have_q;
            if (pwr_valid) begin
                prev_q    <= pwr_value;
                have_q    <= 1'b1;
                slope.dir <= dir_of(diff[DIFF_W-1], diff == '0);
            end
        end
    end
endmodule

// File: rtl/sgt_step_accum.sv
module sgt_step_accum
    import sgt_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  slope_t            slope,
    output logic [CODE_W-1:0] code,
    output logic              code_vld
);
    localparam int XW = CODE_W + 2;
    localparam logic signed [XW-1:0] MAX_X  = XW'((2 ** (CODE_W - 1)) - 1);
    localparam logic signed [XW-1:0] MIN_X  = -XW'(2 ** (CODE_W - 1));
    localparam logic signed [XW-1:0] STEP_X = XW'(STEP);

    logic signed [XW-1:0] code_x;
    logic signed [XW-1:0] sum;
    logic [CODE_W-1:0]    next_code;

    assign code_x = XW'($signed(code));

    always_comb begin
        unique case (slope.dir)
            DIR_UP:   sum = code_x + STEP_X;
            DIR_DOWN: sum = code_x - STEP_X;
            default:  sum = code_x;
        endcase
        if (sum > MAX_X)      next_code = MAX_X[CODE_W-1:0];
        else if (sum < MIN_X) next_code = MIN_X[CODE_W-1:0];
        else                  next_code = sum[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code     <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= slope.vld;
            if (slope.vld) code <= next_code;
        end
    end
endmodule

// File: rtl/sign_grad_tracker.sv
module sign_grad_tracker
    import sgt_pkg::*;
#(
    parameter int PWR_W  = 16,
    parameter int CODE_W = 12,
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_valid,
    input  logic [PWR_W-1:0]  pwr_value,
    output logic [CODE_W-1:0] est_code,
    output logic              est_valid
);
    // one increment is 1/32 LSB expressed in code units
    localparam int STEP_CODE = 1 << (FRAC_W - 5);

    slope_t slope;

    sgt_slope_sense #(.PWR_W(PWR_W)) u_sense (
        .clk       (clk),
        .rst       (rst),
        .pwr_valid (pwr_valid),
        .pwr_value (pwr_value),
        .slope     (slope)
    );

    sgt_step_accum #(.CODE_W(CODE_W), .STEP(STEP_CODE)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .slope    (slope),
        .code     (est_code),
        .code_vld (est_valid)
    );
endmodule

// File: rtl/sgt_check.sv
module sgt_check #(
    parameter int CODE_W = 12,
    parameter int STEP   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_valid,
    input logic [CODE_W-1:0] est_code,
    input logic              est_valid
);
    localparam int XW = CODE_W + 2;

    logic [CODE_W-1:0]    code_q;
    logic                 seen_q, first_d1, first_d2, strb_d1, strb_d2;
    logic signed [XW-1:0] delta;

    assign delta = XW'($signed(est_code)) - XW'($signed(code_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0; seen_q <= 1'b0;
            first_d1 <= 1'b0; first_d2 <= 1'b0;
            strb_d1 <= 1'b0; strb_d2 <= 1'b0;
        end else begin
            code_q   <= est_code;
            seen_q   <= seen_q | pwr_valid;
            first_d1 <= pwr_valid && !seen_q;
            first_d2 <= first_d1;
            strb_d1  <= pwr_valid;
            strb_d2  <= strb_d1;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (est_code == '0 && !est_valid));

    assert_first_silent_R2: assert property (@(posedge clk) disable iff (rst)
        first_d2 |-> !est_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !est_valid |-> est_code == code_q);

    // a single update moves at most one increment, so no wrap (R6, R7)
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        est_valid |-> (delta <= XW'(STEP) && delta >= -XW'(STEP)));

    assert_pulse_origin_R10: assert property (@(posedge clk) disable iff (rst)
        est_valid |-> strb_d2);
endmodule

bind sign_grad_tracker sgt_check #(.CODE_W(CODE_W), .STEP(STEP_CODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_valid (pwr_valid),
    .est_code  (est_code),
    .est_valid (est_valid)
);

// File: tb/tb_sign_grad_tracker.sv
module tb_sign_grad_tracker;
    localparam int PWR_W  = 12;
    localparam int CODE_W = 8;
    localparam int FRAC_W = 5;
    localparam int MAXV   = 127;
    localparam int MINV   = -128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwr_valid = 1'b0;
    logic [PWR_W-1:0]  pwr_value = '0;
    logic [CODE_W-1:0] est_code;
    logic              est_valid;

    int checks = 0, errors = 0;
    int exp_code = 0, prev_p = 0;
    bit have = 0, done = 0;

    always #4 clk = ~clk;

    sign_grad_tracker #(.PWR_W(PWR_W), .CODE_W(CODE_W), .FRAC_W(FRAC_W)) dut (
        .clk(clk), .rst(rst), .pwr_valid(pwr_valid), .pwr_value(pwr_value),
        .est_code(est_code), .est_valid(est_valid)
    );

    function automatic int model_next(input int c, input int p, input int q);
        if (p > q) return (c + 1 > MAXV) ? MAXV : c + 1;
        if (p < q) return (c - 1 < MINV) ? MINV : c - 1;
        return c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; pwr_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_code = 0; have = 0;
        check("R1 code", $signed(est_code), 0);
        check("R1 valid", est_valid, 0);
    endtask

    // strobe one power value, then sample two edges later
    task automatic strobe(input int p, input string req);
        @(negedge clk); pwr_valid = 1'b1; pwr_value = PWR_W'(p);
        @(negedge clk); pwr_valid = 1'b0;
        @(negedge clk);
        if (!have) begin
            check({req, " R2 valid"}, est_valid, 0);
            check({req, " R2 code"}, $signed(est_code), exp_code);
            have = 1;
        end else begin
            exp_code = model_next(exp_code, p, prev_p);
            check({req, " R10 valid"}, est_valid, 1);
            check({req, " code"}, $signed(est_code), exp_code);
        end
        prev_p = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        strobe(100, "R2 first");
        strobe(150, "R3 up");
        strobe(90,  "R4 down");
        strobe(90,  "R5 equal");
        // R10: pulse lasts one cycle
        @(negedge clk); check("R10 pulse end", est_valid, 0);
        // R9: idle changes of pwr_value are ignored
        @(negedge clk); pwr_value = 12'd4000;
        repeat (3) @(negedge clk);
        check("R9 idle valid", est_valid, 0);
        check("R8 idle code", $signed(est_code), exp_code);
        strobe(95, "R9 uses strobed");
        // R6: push to the top limit and beyond
        for (int i = 0; i < 140; i++) strobe(200 + i, "R6 sat up");
        check("R6 at max", $signed(est_code), MAXV);
        // R7: push to the bottom limit and beyond
        for (int i = 0; i < 270; i++) strobe(3000 - i, "R7 sat down");
        check("R7 at min", $signed(est_code), MINV);
        // R2 again after a mid-run reset
        do_reset();
        strobe(10, "R2 after reset");
        // random mix, narrow range so equality occurs
        for (int i = 0; i < 300; i++) strobe(int'($urandom_range(0, 6)), "R3/R4/R5 random");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule